// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM with one shared data bus. It is built so that reads and writes can alternate on consecutive clock cycles without idle cycles. Address and control inputs are registered on the rising clock edge. Read data leaves through an output register one edge after the address edge. Write data is taken one edge later still, which puts it two edges after its address. The read-data slot and the write-data slot of neighbouring operations therefore never collide on the bus. The tristate bus is split into `din`, `dout` and an output-enable flag `dout_oe`.

An access starts on an edge where the clock enable is active and all three chip selects are active while the load strobe is low. On such an edge the write-enable level picks read or write. If a chip select is inactive at a load edge, the result is a deselect, and it moves through the same pipeline as the other operations. With the load strobe high, the block continues the previous operation at the next address of a four-beat burst. The burst runs through the two low address bits, in linear or interleaved order. While the clock enable is inactive, the whole pipeline freezes.

Top module: `zt_sram`

## Requirements
- R1: A read started at edge E0 gives `dout_oe`=1 and the stored word on `dout` after edge E1, provided `out_en_n` is low.
- R2: For a write started at edge E0, `dout_oe` is 0 after edge E1 whatever `out_en_n` is. `din` and `byte_we_n` are captured at edge E2.
- R3: Byte i is bits [9i+8:9i] of the word and is written only when `byte_we_n[i]`=0. Bytes with `byte_we_n[i]`=1 keep their old value.
- R4: If any chip select is inactive at a load edge, the result is a deselect, and `dout_oe` is 0 after the following edge.
- R5: An edge with `clk_en_n`=1 changes nothing. `dout` and the drive state are held, no write data is captured, and no operation advances.
- R6: A new operation can be issued on every enabled edge. A read issued one edge after a write to the same address returns the newly written bytes.
- R7: `out_en_n`=1 forces `dout_oe` to 0 at once, with no clock edge needed.
- R8: With `burst_mode`=0, a load edge with `load_n`=1 repeats the previous operation type. Its address keeps the upper bits of the start address, and its two low bits are (start+k) mod 4 for the k-th advance.
- R9: With `burst_mode`=1, the two low address bits of the k-th advance are start XOR (k mod 4).
- R10: An advance edge ignores the chip selects and `wr_n`. An advance after a deselect therefore stays a deselect and writes nothing.
- R11: While `rst_n` is low and after reset, `dout_oe` is 0 until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of pipeline state |
| clk_en_n | input | 1 | Active-low clock enable; high holds all state |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low: load a new address; high: advance burst |
| wr_n | input | 1 | Low: write, high: read (sampled at load) |
| byte_we_n | input | BYTES | Per-byte write enables, active low, taken with data |
| burst_mode | input | 1 | 0 linear burst order, 1 interleaved |
| addr | input | ADDR_W | Word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | BYTES*BYTE_W | Write data bus |
| dout | output | BYTES*BYTE_W | Read data from the output register |
| dout_oe | output | 1 | High when the model drives `dout` onto the bus |

## Verification
The bench aims at a read that follows a write to the same address on the next edge. A model without forwarding would return the stale word. It also holds stalls inside write and read slots: a model that captured data while stalled, or that let the output register slip, would corrupt memory or show a word early. Burst advances that wrap in both orders are exercised, since a wrong carry or a wrong order would fetch the wrong word. So is an advance that follows a deselect, where a model that honoured the chip selects or `wr_n` would start a phantom write. `out_en_n` is also toggled between edges, because a registered output enable would lag by one cycle.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    load_n,
  input  logic                    wr_n,
  input  logic [BYTES-1:0]        byte_we_n,
  input  logic                    burst_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    out_en_n,
  input  logic [BYTES*BYTE_W-1:0] din,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_oe
);
  localparam int DW    = BYTES * BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_t;

  logic [DW-1:0]     mem [DEPTH];
  op_t               s1_op, iss_op;
  logic [ADDR_W-1:0] s1_addr, iss_addr, base;
  logic [1:0]        bcnt, nxt_cnt, seq_lo;
  logic              w_pend, drive_r, sel, ce;
  logic [ADDR_W-1:0] w_addr;
  logic [DW-1:0]     dout_r, fwd;

  assign ce      = !clk_en_n;
  assign sel     = !cs0_n && cs1 && !cs2_n;
  assign nxt_cnt = bcnt + 2'd1;
  assign seq_lo  = burst_mode ? (base[1:0] ^ nxt_cnt) : (base[1:0] + nxt_cnt);

  always_comb begin
    if (!load_n) begin
      iss_op   = sel ? (wr_n ? OP_RD : OP_WR) : OP_NONE;
      iss_addr = addr;
    end else begin
      iss_op   = s1_op;
      iss_addr = {base[ADDR_W-1:2], seq_lo};
    end
  end

  generate
    for (genvar i = 0; i < BYTES; i++) begin : g_fwd
      assign fwd[i*BYTE_W +: BYTE_W] =
        (w_pend && w_addr == s1_addr && !byte_we_n[i]) ? din[i*BYTE_W +: BYTE_W]
                                                       : mem[s1_addr][i*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_op   <= OP_NONE;
      s1_addr <= '0;
      base    <= '0;
      bcnt    <= '0;
      w_pend  <= 1'b0;
      w_addr  <= '0;
      drive_r <= 1'b0;
    end else if (ce) begin
      s1_op   <= iss_op;
      s1_addr <= iss_addr;
      if (!load_n) begin
        base <= addr;
        bcnt <= '0;
      end else begin
        bcnt <= nxt_cnt;
      end
      w_pend  <= (s1_op == OP_WR);
      w_addr  <= s1_addr;
      drive_r <= (s1_op == OP_RD);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && ce && s1_op == OP_RD) dout_r <= fwd;
  end

  always_ff @(posedge clk) begin
    if (rst_n && ce && w_pend) begin
      for (int i = 0; i < BYTES; i++)
        if (!byte_we_n[i]) mem[w_addr][i*BYTE_W +: BYTE_W] <= din[i*BYTE_W +: BYTE_W];
    end
  end

  assign dout    = dout_r;
  assign dout_oe = drive_r && !out_en_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          cs0_n,
  input logic          cs1,
  input logic          cs2_n,
  input logic          load_n,
  input logic          wr_n,
  input logic          out_en_n,
  input logic [DW-1:0] dout,
  input logic          dout_oe,
  input logic          drive_r
);
  logic on;
  assign on = !cs0_n && cs1 && !cs2_n;

  // R1
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && on && wr_n) ##1 !clk_en_n |=> (dout_oe == !out_en_n));

  // R2
  wr_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && on && !wr_n) ##1 !clk_en_n |=> !dout_oe);

  // R4
  desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && !on) ##1 !clk_en_n |=> !dout_oe);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(dout) && $stable(drive_r)));

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dout_oe);
endmodule

bind zt_sram zt_sram_chk #(.DW(BYTES*BYTE_W)) u_chk (.*);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int BWD = 9;
  localparam int DW = NB * BWD;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, c0_n = 1'b1, c1 = 1'b0, c2_n = 1'b1, ld_n = 1'b0, w_n = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic bmode = 1'b0;
  logic [AW-1:0] a = '0;
  logic oe_n = 1'b0;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] dout;
  logic dout_oe;

  int checks = 0, fails = 0;

  logic [DW-1:0] refm [DEPTH];
  int e_op1 = 0, e_k = 0;
  logic [AW-1:0] e_a1 = '0, e_wa = '0, e_base = '0;
  logic e_wp = 1'b0, e_drv = 1'b0;
  logic [DW-1:0] e_dout = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BWD)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(ce_n), .cs0_n(c0_n), .cs1(c1), .cs2_n(c2_n),
    .load_n(ld_n), .wr_n(w_n), .byte_we_n(bw_n), .burst_mode(bmode), .addr(a),
    .out_en_n(oe_n), .din(d), .dout(dout), .dout_oe(dout_oe));

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [1:0] lo;
    if (!rst_n) begin
      e_op1 = 0; e_wp = 1'b0; e_drv = 1'b0; e_k = 0;
      return;
    end
    if (ce_n) return;
    if (e_wp)
      for (int i = 0; i < NB; i++)
        if (!bw_n[i]) refm[e_wa][i*BWD +: BWD] = d[i*BWD +: BWD];
    e_drv = (e_op1 == 1);
    if (e_drv) e_dout = refm[e_a1];
    e_wp = (e_op1 == 2);
    e_wa = e_a1;
    if (!ld_n) begin
      e_op1 = (!c0_n && c1 && !c2_n) ? (w_n ? 1 : 2) : 0;
      e_a1 = a; e_base = a; e_k = 0;
    end else begin
      e_k = (e_k + 1) % 4;
      lo = bmode ? (e_base[1:0] ^ 2'(e_k)) : (e_base[1:0] + 2'(e_k));
      e_a1 = {e_base[AW-1:2], lo};
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "dout_oe", 32'(dout_oe), 32'(e_drv && !oe_n));
    if (e_drv && !oe_n) chk(tag, "dout", 32'(dout), 32'(e_dout));
  endtask

  task automatic selon(); c0_n = 1'b0; c1 = 1'b1; c2_n = 1'b0; endtask

  task automatic op_rd(input logic [AW-1:0] ad, input string tag);
    ce_n = 1'b0; selon(); ld_n = 1'b0; w_n = 1'b1; a = ad; d = DW'($urandom); tick(tag);
  endtask

  task automatic op_wr(input logic [AW-1:0] ad, input string tag);
    ce_n = 1'b0; selon(); ld_n = 1'b0; w_n = 1'b0; a = ad; d = DW'($urandom); tick(tag);
  endtask

  task automatic op_desel(input string tag);
    ce_n = 1'b0; c0_n = 1'b1; ld_n = 1'b0; w_n = 1'b1; a = AW'($urandom); d = DW'($urandom); tick(tag);
  endtask

  task automatic op_adv(input string tag);
    ce_n = 1'b0; ld_n = 1'b1; d = DW'($urandom); tick(tag);
  endtask

  task automatic op_stall(input string tag);
    ce_n = 1'b1; ld_n = 1'b0; selon(); w_n = 1'b0; d = DW'($urandom); a = AW'($urandom); tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    // R11 reset state
    rst_n = 1'b0;
    tick("R11"); tick("R11");
    rst_n = 1'b1;
    op_desel("R11");
    chk("R11", "dout_oe after reset", 32'(dout_oe), 32'd0);

    // fill every word with full-byte writes (R2: bus stays off)
    bw_n = '0;
    for (int i = 0; i < DEPTH; i++) op_wr(AW'(i), "R2");
    op_desel("R2"); op_desel("R2");

    // R1 single reads
    for (int i = 0; i < 4; i++) op_rd(AW'(i * 3), "R1");
    op_desel("R1"); op_desel("R1");

    // R2 write with output enable low, then read back
    oe_n = 1'b0;
    op_wr(4'd5, "R2"); op_desel("R2"); op_desel("R2"); op_rd(4'd5, "R2"); op_desel("R2");

    // R3 partial byte writes
    bw_n = 2'b10;
    op_wr(4'd7, "R3"); op_desel("R3"); op_desel("R3");
    bw_n = 2'b01;
    op_wr(4'd8, "R3"); op_desel("R3"); op_desel("R3");
    bw_n = 2'b11;
    op_wr(4'd9, "R3"); op_desel("R3"); op_desel("R3");
    bw_n = '0;
    op_rd(4'd7, "R3"); op_rd(4'd8, "R3"); op_rd(4'd9, "R3"); op_desel("R3");

    // R4 deselect between reads
    op_rd(4'd1, "R4"); op_desel("R4"); op_rd(4'd2, "R4");
    c1 = 1'b0; ld_n = 1'b0; ce_n = 1'b0; tick("R4");
    op_desel("R4");

    // R6 back-to-back write then read of the same address
    op_wr(4'd10, "R6"); op_rd(4'd10, "R6"); op_wr(4'd11, "R6"); op_rd(4'd11, "R6");
    op_wr(4'd12, "R6"); op_wr(4'd13, "R6"); op_rd(4'd12, "R6"); op_rd(4'd13, "R6");
    op_desel("R6"); op_desel("R6");

    // R5 stalls inside write and read slots
    op_wr(4'd3, "R5"); op_stall("R5"); op_stall("R5"); op_rd(4'd3, "R5");
    op_stall("R5"); op_stall("R5"); op_desel("R5"); op_stall("R5"); op_desel("R5");

    // R7 output enable acts between edges
    oe_n = 1'b1;
    op_rd(4'd4, "R7"); op_desel("R7");
    chk("R7", "dout_oe with out_en_n high", 32'(dout_oe), 32'd0);
    oe_n = 1'b0; #1;
    chk("R7", "dout_oe after out_en_n low", 32'(dout_oe), 32'd1);
    oe_n = 1'b1; #1;
    chk("R7", "dout_oe after out_en_n high", 32'(dout_oe), 32'd0);
    oe_n = 1'b0;
    op_desel("R7");

    // R8 linear burst read with wrap, then linear burst write
    bmode = 1'b0;
    op_rd(4'd6, "R8"); for (int i = 0; i < 5; i++) op_adv("R8");
    op_wr(4'd9, "R8"); for (int i = 0; i < 3; i++) op_adv("R8");
    op_desel("R8"); op_desel("R8");
    op_rd(4'd8, "R8"); for (int i = 0; i < 3; i++) op_adv("R8");
    op_desel("R8");

    // R9 interleaved burst
    bmode = 1'b1;
    op_rd(4'd13, "R9"); for (int i = 0; i < 4; i++) op_adv("R9");
    op_wr(4'd6, "R9"); for (int i = 0; i < 3; i++) op_adv("R9");
    op_desel("R9"); op_desel("R9");
    op_rd(4'd4, "R9"); for (int i = 0; i < 3; i++) op_adv("R9");
    op_desel("R9");

    // R10 advance after deselect ignores selects and wr_n
    bmode = 1'b0;
    op_desel("R10");
    selon(); w_n = 1'b0;
    for (int i = 0; i < 3; i++) begin ce_n = 1'b0; ld_n = 1'b1; d = DW'($urandom); tick("R10"); end
    op_rd(4'd0, "R10"); op_rd(4'd1, "R10"); op_rd(4'd2, "R10"); op_rd(4'd3, "R10");
    op_desel("R10");

    // R6 random back-to-back traffic
    for (int blk = 0; blk < 6; blk++) begin
      bmode = blk[0];
      for (int n = 0; n < 500; n++) begin
        ce_n = ($urandom % 10) == 0;
        ld_n = ($urandom % 4) == 0;
        selon();
        case ($urandom % 12)
          0: c0_n = 1'b1;
          1: c1 = 1'b0;
          2: c2_n = 1'b1;
          default: ;
        endcase
        w_n  = $urandom % 2;
        a    = AW'($urandom);
        bw_n = NB'($urandom);
        d    = DW'($urandom);
        oe_n = ($urandom % 6) == 0;
        tick("R6");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule